// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a 16-bit parallel NOR flash bus. It drives word programs and erases of three sizes: one sector, one block, or the whole device. A client presents one request made of an operation code, a word address and a data word. The sequencer then writes the unlock command sequence onto the bus, shaping each chip-enable, output-enable and write-enable pulse to minimum widths. Every width is set in clock cycles.

Once the command is written, the sequencer reads the bus repeatedly and watches the status line that alternates while the flash is busy. When two successive reads agree, it reads twice more before it accepts the result. After that it observes a bus recovery gap and then pulses done. A per-operation watchdog ends a run that never settles by pulsing err.

Top module: `nor_pe_sequencer`

## Requirements
- R1: A program request (op code 0) issues four write cycles, given as (address, data) in hex: (5555, 00AA), (2AAA, 0055), (5555, 00A0), then (request address, request data).
- R2: An erase request issues six write cycles. The first five are (5555, 00AA), (2AAA, 0055), (5555, 0080), (5555, 00AA), (2AAA, 0055). The sixth is (request address, 0030) for sector erase (op 1), (request address, 0050) for block erase (op 2), or (5555, 0010) for chip erase (op 3).
- R3: In every write cycle, write enable stays low for at least T_WP cycles, and it stays high for at least T_WPH cycles between pulses. While write enable is low, chip enable is low, output enable is high, and the data driver is on. Address and data hold steady through the whole low pulse.
- R4: Before a status read lowers output enable, the data driver has been off and write enable high for at least T_OEH cycles. Output enable then stays low for at least T_RD cycles.
- R5: The status bit is flash_stat_in. Suppose it alternates on each of the first K reads (K ≥ 1) and then stops. With no spurious agreement, completion is reached after exactly K+3 reads: the first agreeing read plus two confirming reads.
- R6: Suppose the status bit fails to alternate once while the flash is still busy. The confirming read then disagrees, polling resumes, and no done appears early. With K alternations and one skipped alternation, done follows exactly K+4 reads.
- R7: After the last status read ends, output enable stays high for at least T_BR cycles before done pulses.
- R8: The watchdog starts after the last command write and uses the limit for the current operation: PROG_TIMEOUT, SECT_TIMEOUT, BLK_TIMEOUT or CHIP_TIMEOUT. If the status never settles, err pulses at the end of the first read that completes after the limit. done does not pulse in that run.
- R9: A request is taken only while idle, and busy rises in the next cycle. busy falls in the same cycle that done or err pulses for one cycle. A request that arrives while busy issues no write, either during or after the running operation.
- R10: After reset, chip enable, output enable and write enable are high, the data driver is off, and busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Word address for program, sector or block |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on watchdog timeout |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | DW | Write data toward the flash |
| flash_dq_oe | output | 1 | Write data driver enable |
| flash_stat_in | input | 1 | Toggling status line of the flash data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
Each kind of fault shows up at the ports at a different point:
- A wrong command step or a miscounted step index puts a wrong address or code on the bus at the rising write-enable edge of that very cycle.
- A wrong strobe counter shows in the pulse widths within one write cycle.
- A poll-phase fault changes how many reads happen before done. It appears at most two reads after the status line settles, or earlier when a skipped alternation is taken as completion.
- A watchdog fault moves err away from its expected window just past the limit, or makes it disappear.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } nps_op_e;

  typedef enum logic [2:0] {
    BC_IDLE, BC_WSET, BC_WLOW, BC_WHIGH, BC_RGAP, BC_RLOW
  } bc_phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_GO, S_WR_WAIT, S_RD_GO, S_RD_WAIT, S_RECOVER, S_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_FIRST, PH_CMP, PH_VER1, PH_VER2
  } poll_phase_e;

  localparam logic [31:0] UNLOCK_A = 32'h0000_5555;
  localparam logic [31:0] UNLOCK_B = 32'h0000_2AAA;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [2:0] seq_len(nps_op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  function automatic logic [31:0] step_addr(nps_op_e op, logic [2:0] step,
                                            logic [31:0] uaddr);
    case (step)
      3'd0, 3'd2: return UNLOCK_A;
      3'd1, 3'd4: return UNLOCK_B;
      3'd3:       return (op == OP_PROG) ? uaddr : UNLOCK_A;
      default:    return (op == OP_CHIP) ? UNLOCK_A : uaddr;
    endcase
  endfunction

  function automatic logic [7:0] step_code(nps_op_e op, logic [2:0] step);
    case (step)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return (op == OP_PROG) ? 8'hA0 : 8'h80;
      default: begin
        case (op)
          OP_SECT: return 8'h30;
          OP_BLK:  return 8'h50;
          default: return 8'h10;
        endcase
      end
    endcase
  endfunction

  function automatic logic is_data_step(nps_op_e op, logic [2:0] step);
    return (op == OP_PROG) && (step == 3'd3);
  endfunction

endpackage

// File: rtl/nps_watchdog.sv
module nps_watchdog #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: once expired, stays expired until the next clear
  a_r8_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/nps_bus_cycle.sv
module nps_bus_cycle
  import nps_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int T_WP  = 2,
  parameter int T_WPH = 2,
  parameter int T_OEH = 1,
  parameter int T_RD  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic          rd_bit,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_dq_out,
  output logic          f_dq_oe,
  input  logic          f_stat_in,
  output logic          f_ce_n,
  output logic          f_oe_n,
  output logic          f_we_n
);

  localparam int TMAX = max4(T_WP, T_WPH, T_OEH, T_RD);
  localparam int CW   = $clog2(TMAX + 1);

  bc_phase_e     ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_last;
  logic          phase_end;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rd_q;
  logic          done_q;

  always_comb begin
    case (ph)
      BC_WLOW:  cur_last = CW'(T_WP - 1);
      BC_WHIGH: cur_last = CW'(T_WPH - 1);
      BC_RGAP:  cur_last = CW'(T_OEH - 1);
      BC_RLOW:  cur_last = CW'(T_RD - 1);
      default:  cur_last = '0;
    endcase
  end

  assign phase_end = (cnt == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= BC_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        BC_IDLE: begin
          if (start) begin
            addr_q <= addr;
            data_q <= wdata;
            cnt    <= '0;
            ph     <= wr ? BC_WSET : BC_RGAP;
          end
        end
        BC_WSET: begin
          cnt <= '0;
          ph  <= BC_WLOW;
        end
        BC_WLOW, BC_WHIGH, BC_RGAP: begin
          if (phase_end) begin
            cnt <= '0;
            if (ph == BC_WLOW) begin
              ph <= BC_WHIGH;
            end else if (ph == BC_RGAP) begin
              ph <= BC_RLOW;
            end else begin
              ph     <= BC_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BC_RLOW: begin
          if (phase_end) begin
            rd_q   <= f_stat_in;
            done_q <= 1'b1;
            cnt    <= '0;
            ph     <= BC_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= BC_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign rd_bit   = rd_q;
  assign f_addr   = addr_q;
  assign f_dq_out = data_q;
  assign f_ce_n   = (ph == BC_IDLE);
  assign f_we_n   = (ph != BC_WLOW);
  assign f_oe_n   = (ph != BC_RLOW);
  assign f_dq_oe  = (ph == BC_WSET) || (ph == BC_WLOW) || (ph == BC_WHIGH);

  // R3: write and read strobes never overlap
  a_r3_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!f_we_n && !f_oe_n));

  // R3: the write pulse happens with the chip selected and the data driven
  a_r3_we_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> (f_dq_oe && !f_ce_n));

  // R3: address and data hold steady through a write pulse
  a_r3_we_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_out)));

  // R4: the driver was already off in the cycle before output enable falls
  a_r4_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_oe_n) |-> (!$past(f_dq_oe) && $past(f_we_n)));

endmodule

// File: rtl/nor_pe_sequencer.sv
module nor_pe_sequencer
  import nps_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter int T_WP         = 2,
  parameter int T_WPH        = 2,
  parameter int T_OEH        = 1,
  parameter int T_RD         = 4,
  parameter int T_BR         = 50,
  parameter int WD_W         = 24,
  parameter int PROG_TIMEOUT = 2000,
  parameter int SECT_TIMEOUT = 1500000,
  parameter int BLK_TIMEOUT  = 1500000,
  parameter int CHIP_TIMEOUT = 6000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_out,
  output logic          flash_dq_oe,
  input  logic          flash_stat_in,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n
);

  localparam int BRW = $clog2(T_BR + 1) + 1;

  seq_state_e    st;
  poll_phase_e   phase;
  nps_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step;
  logic          prev_bit;
  logic [BRW-1:0] br_cnt;
  logic          fail_q;

  logic          cyc_start, cyc_wr, cyc_done, cyc_bit;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          last_step, poll_match, accept;
  logic          wd_clear, wd_run, wd_expired;
  logic [WD_W-1:0] wd_limit;

  assign accept     = (st == S_IDLE) && req_valid;
  assign last_step  = (step == seq_len(op_q) - 3'd1);
  assign poll_match = (cyc_bit == prev_bit);
  assign cyc_start  = (st == S_WR_GO) || (st == S_RD_GO);
  assign cyc_wr     = (st == S_WR_GO);
  assign cyc_addr   = AW'(step_addr(op_q, step, 32'(addr_q)));
  assign cyc_data   = is_data_step(op_q, step) ? data_q
                                               : DW'(step_code(op_q, step));
  assign wd_clear   = (st == S_WR_WAIT) && cyc_done && last_step;
  assign wd_run     = (st == S_RD_GO) || (st == S_RD_WAIT);

  always_comb begin
    case (op_q)
      OP_PROG: wd_limit = WD_W'(PROG_TIMEOUT);
      OP_SECT: wd_limit = WD_W'(SECT_TIMEOUT);
      OP_BLK:  wd_limit = WD_W'(BLK_TIMEOUT);
      default: wd_limit = WD_W'(CHIP_TIMEOUT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= PH_FIRST;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      step     <= '0;
      prev_bit <= 1'b0;
      br_cnt   <= '0;
      fail_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= nps_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step   <= '0;
            fail_q <= 1'b0;
            st     <= S_WR_GO;
          end
        end
        S_WR_GO: st <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (cyc_done) begin
            if (last_step) begin
              phase <= PH_FIRST;
              st    <= S_RD_GO;
            end else begin
              step <= step + 3'd1;
              st   <= S_WR_GO;
            end
          end
        end
        S_RD_GO: st <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (cyc_done) begin
            if (wd_expired) begin
              fail_q <= 1'b1;
              st     <= S_FIN;
            end else begin
              prev_bit <= cyc_bit;
              st       <= S_RD_GO;
              case (phase)
                PH_FIRST: phase <= PH_CMP;
                PH_CMP:   if (poll_match) phase <= PH_VER1;
                PH_VER1:  phase <= poll_match ? PH_VER2 : PH_CMP;
                default: begin
                  if (poll_match) begin
                    br_cnt <= '0;
                    st     <= S_RECOVER;
                  end else begin
                    phase <= PH_CMP;
                  end
                end
              endcase
            end
          end
        end
        S_RECOVER: begin
          if (br_cnt == BRW'(T_BR - 1)) st <= S_FIN;
          else br_cnt <= br_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE) && (st != S_FIN);
  assign done = (st == S_FIN) && !fail_q;
  assign err  = (st == S_FIN) && fail_q;

  nps_bus_cycle #(
    .AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH), .T_OEH(T_OEH), .T_RD(T_RD)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cyc_start),
    .wr        (cyc_wr),
    .addr      (cyc_addr),
    .wdata     (cyc_data),
    .done      (cyc_done),
    .rd_bit    (cyc_bit),
    .f_addr    (flash_addr),
    .f_dq_out  (flash_dq_out),
    .f_dq_oe   (flash_dq_oe),
    .f_stat_in (flash_stat_in),
    .f_ce_n    (flash_ce_n),
    .f_oe_n    (flash_oe_n),
    .f_we_n    (flash_we_n)
  );

  nps_watchdog #(.W(WD_W)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wd_clear),
    .run     (wd_run),
    .limit   (wd_limit),
    .expired (wd_expired)
  );

  // cycles with output enable high since the last read, for the R7 check
  logic [BRW:0] oe_quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_quiet <= '0;
    else if (!flash_oe_n) oe_quiet <= '0;
    else if (oe_quiet != {(BRW+1){1'b1}}) oe_quiet <= oe_quiet + 1'b1;
  end

  a_r7_recover_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (oe_quiet >= (BRW+1)'(T_BR)));

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r9_end_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8: an error is only reported once the watchdog has run out
  a_r8_err_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(wd_expired));

endmodule

// File: tb/nor_pe_sequencer_bench.sv
module nor_pe_sequencer_bench;
  localparam int AW = 20, DW = 16;
  localparam int T_WP = 2, T_WPH = 2, T_OEH = 1, T_RD = 4, T_BR = 50;
  localparam int CHIP_TO = 3000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic busy, done, err, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_dq;
  logic stat = 0;

  always #10 clk = ~clk;

  nor_pe_sequencer #(.AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH),
    .T_OEH(T_OEH), .T_RD(T_RD), .T_BR(T_BR), .PROG_TIMEOUT(2000),
    .SECT_TIMEOUT(5000), .BLK_TIMEOUT(5000), .CHIP_TIMEOUT(CHIP_TO))
  u_nor_pe_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .err(err), .flash_addr(f_addr), .flash_dq_out(f_dq), .flash_dq_oe(dq_oe),
    .flash_stat_in(stat), .flash_ce_n(ce_n), .flash_oe_n(oe_n),
    .flash_we_n(we_n));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model
  int toggle_left = 0, glitch_at = 0, rd_count = 0, wr_count = 0;
  logic [AW-1:0] wa [0:15];
  logic [DW-1:0] wdv [0:15];

  always @(negedge oe_n) if (rst_n && !ce_n) begin
    rd_count++;
    if (toggle_left > 0 && rd_count != glitch_at) begin
      stat = ~stat;
      toggle_left--;
    end
  end

  always @(posedge we_n) if (rst_n && !ce_n && wr_count < 16) begin
    wa[wr_count] = f_addr;
    wdv[wr_count] = f_dq;
    wr_count++;
  end

  // strobe timing monitor
  int low_run = 0, high_run = 0, min_low = 999, min_high = 999;
  int since_we = 999, min_gap = 999, olow = 0, min_olow = 999, quiet = 0;
  int bad_w = 0;
  bit prev_we = 1, prev_oe = 1, seen_low = 0;
  logic [AW-1:0] lat_a;
  logic [DW-1:0] lat_d;

  always @(negedge clk) if (rst_n) begin
    if (!we_n) begin
      if (prev_we) begin
        lat_a = f_addr; lat_d = f_dq; low_run = 1;
        if (seen_low && high_run < min_high) min_high = high_run;
      end else low_run++;
      if (f_addr != lat_a || f_dq != lat_d || !dq_oe || ce_n || !oe_n) bad_w++;
    end else begin
      if (!prev_we) begin
        if (low_run < min_low) min_low = low_run;
        high_run = 1; since_we = 1; seen_low = 1;
      end else begin
        high_run++; since_we++;
      end
    end
    if (!oe_n) begin
      if (prev_oe) begin
        if (since_we < min_gap) min_gap = since_we;
        if (dq_oe) bad_w++;
        olow = 1;
      end else olow++;
    end else begin
      if (!prev_oe) begin
        if (olow < min_olow) min_olow = olow;
        quiet = 1;
      end else quiet++;
    end
    prev_we = we_n; prev_oe = oe_n;
  end

  function automatic logic [AW-1:0] exp_a(int op, int i, logic [AW-1:0] a);
    if (i == 0 || i == 2) return 20'h05555;
    if (i == 1 || i == 4) return 20'h02AAA;
    if (i == 3) return (op == 0) ? a : 20'h05555;
    return (op == 3) ? 20'h05555 : a;
  endfunction

  function automatic logic [DW-1:0] exp_d(int op, int i, logic [DW-1:0] d);
    case (i)
      0, 3: return (i == 3 && op == 0) ? d : 16'h00AA;
      1, 4: return 16'h0055;
      2: return (op == 0) ? 16'h00A0 : 16'h0080;
      default: return (op == 1) ? 16'h0030 : (op == 2) ? 16'h0050 : 16'h0010;
    endcase
  endfunction

  // one operation; exp_reads < 0 means an error run is expected
  task automatic run_op(int op, logic [AW-1:0] a, logic [DW-1:0] d, int k,
                        int g, int exp_reads, bit inject, string tag);
    int cyc, nw, qd;
    bit got_done, got_err;
    toggle_left = k; glitch_at = g; rd_count = 0; wr_count = 0;
    min_low = 999; min_high = 999; min_gap = 999; min_olow = 999; bad_w = 0;
    seen_low = 0;
    @(negedge clk);
    req_valid = 1; req_op = op[1:0]; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, {tag, " R9 busy after accept"}, busy, 1);
    cyc = 1;
    while (!(done || err) && cyc < 20000) begin
      if (inject && cyc == 10) begin req_valid = 1; req_op = 2'd3; end
      else req_valid = 0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 0;
    got_done = done; got_err = err; qd = quiet;
    check(busy == 0, {tag, " R9 busy low at end"}, busy, 0);
    nw = (op == 0) ? 4 : 6;
    check(wr_count == nw, {tag, " R1 R2 write count"}, wr_count, nw);
    for (int i = 0; i < nw && i < wr_count; i++) begin
      check(wa[i] == exp_a(op, i, a), {tag, " R1 R2 write address"},
            wa[i], exp_a(op, i, a));
      check(wdv[i] == exp_d(op, i, d), {tag, " R1 R2 write data"},
            wdv[i], exp_d(op, i, d));
    end
    check(min_low >= T_WP, {tag, " R3 we low width"}, min_low, T_WP);
    check(min_high >= T_WPH, {tag, " R3 we high width"}, min_high, T_WPH);
    check(bad_w == 0, {tag, " R3 strobe/data integrity"}, bad_w, 0);
    check(min_gap >= T_OEH, {tag, " R4 oe gap after write"}, min_gap, T_OEH);
    check(min_olow >= T_RD, {tag, " R4 oe low width"}, min_olow, T_RD);
    if (exp_reads >= 0) begin
      check(got_done && !got_err, {tag, " R5 done reported"}, got_done, 1);
      check(rd_count == exp_reads, {tag, " R5 R6 read count"},
            rd_count, exp_reads);
      check(qd >= T_BR && qd <= T_BR + 3, {tag, " R7 recovery gap"}, qd, T_BR);
    end else begin
      check(got_err && !got_done, {tag, " R8 err without done"}, got_err, 1);
      check(cyc >= CHIP_TO && cyc <= CHIP_TO + 100, {tag, " R8 err timing"},
            cyc, CHIP_TO);
    end
    repeat (20) @(negedge clk);
    check(wr_count == nw && !busy, {tag, " R9 no extra operation"},
          wr_count, nw);
  endtask

  task automatic t_reset;
    check(ce_n && oe_n && we_n, "R10 strobes high", {ce_n, oe_n, we_n}, 3'b111);
    check(!dq_oe, "R10 driver off", dq_oe, 0);
    check(!busy && !done && !err, "R10 status low", {busy, done, err}, 0);
  endtask

  task automatic t_program;  run_op(0, 20'h1_2345, 16'hBEEF, 3, 0, 6, 0, "prog");  endtask
  task automatic t_sector;   run_op(1, 20'h3_4400, 16'h0, 5, 0, 8, 0, "sect");     endtask
  task automatic t_block;    run_op(2, 20'hF_8000, 16'h0, 1, 0, 4, 0, "blk");      endtask
  task automatic t_chip;     run_op(3, 20'h0, 16'h0, 4, 0, 7, 0, "chip");          endtask
  task automatic t_glitch;   run_op(0, 20'h0_0ABC, 16'h5A5A, 6, 3, 10, 0, "R6 glitch"); endtask
  task automatic t_ignore;   run_op(0, 20'h7_0001, 16'h1234, 2, 0, 5, 1, "R9 ignore"); endtask
  task automatic t_timeout;  run_op(3, 20'h0, 16'h0, 1000000, 0, -1, 0, "R8 timeout"); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_program;
    t_sector;
    t_block;
    t_chip;
    t_glitch;
    t_ignore;
    t_timeout;
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule